// File: doc/BRIEF.md
# Receive Character Buffer with Threshold Request

This block sits between a serial receiver and the host that consumes its characters. Each time the receiver finishes a character it strobes the block with the byte and three status bits: parity error, framing error and line break. The block stores the byte and its status bits together as one entry. The host drains the entries in arrival order. Because up to sixteen characters can wait in the buffer, the host only has to service the receiver now and then, not once per character.

The host picks one of four fill thresholds. A data-available request is raised while the number of stored characters is at or above that threshold, so the host can wait until a useful batch has built up. A character that arrives while all sixteen slots are occupied is dropped, and a sticky overrun flag records the loss until the host clears it.

The write side carries no back-pressure: the receiver cannot pause the line, so there is no ready signal toward it, and the overrun flag is the only sign that a character was lost. The read side is a pop strobe. The popped entry appears on registered outputs one cycle later and stays there until the next successful pop.

Top module: `rx_fifo_trig`

## Requirements
- R1: Entries leave in the order they arrived. The buffer holds up to 16 entries. `level` gives the current number of entries (0 to 16), and `empty` is high exactly when `level` is 0. A write without a read on a non-full buffer raises `level` by one, one cycle after the strobe.
- R2: Each entry keeps its byte and its three flags together. A successful pop puts that entry's `rd_data`, `rd_par_err`, `rd_frm_err` and `rd_brk` on the outputs on the clock edge that takes the pop. The outputs then hold those values until the next successful pop.
- R3: `trig_sel` chooses the threshold: 0 gives 1 entry, 1 gives 4 entries, 2 gives 8 entries and 3 gives 14 entries. `data_avail` is high whenever `level` is at or above the selected threshold. It follows changes of `level` and `trig_sel` with no added register.
- R4: A write while `level` is 16 and no pop is taken in the same cycle discards the incoming character. The stored entries stay as they were, `level` stays at 16, and `overrun` is set.
- R5: `overrun` stays high until `ovr_clr` is pulsed. If an overrun and a clear happen in the same cycle, the flag ends up set.
- R6: A pop while `empty` is high has no effect: the read outputs keep their previous values and `level` does not change.
- R7: A write and a pop in the same cycle on a full buffer both take effect. `level` stays at 16, no overrun is flagged, and the new character goes to the tail. A write and a pop in the same cycle on an empty buffer store the character, leave the read outputs unchanged and make `level` 1.
- R8: After reset, `level` is 0, `empty` is 1, `data_avail` is 0, `overrun` is 0, and all read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Receiver strobe: one character complete |
| wr_data | input | 8 | Received byte |
| wr_par_err | input | 1 | Parity error status of the character |
| wr_frm_err | input | 1 | Framing error status of the character |
| wr_brk | input | 1 | Break status of the character |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Last popped byte |
| rd_par_err | output | 1 | Parity status of last popped entry |
| rd_frm_err | output | 1 | Framing status of last popped entry |
| rd_brk | output | 1 | Break status of last popped entry |
| trig_sel | input | 2 | Threshold select (0:1, 1:4, 2:8, 3:14) |
| level | output | 5 | Number of stored entries |
| empty | output | 1 | No entries stored |
| data_avail | output | 1 | Fill level at or above threshold |
| overrun | output | 1 | Sticky lost-character flag |
| ovr_clr | input | 1 | Clears the overrun flag |

## Verification
The hardest condition to reach from the ports is a write that coincides with a pop while all sixteen slots are full. The bench reaches it by filling the buffer completely, forcing one overrun, and then issuing a combined write and pop on that full state. It then drains the buffer to show that the dropped character never appears and that the combined write went to the tail. Flag collisions are driven on purpose: a clear issued in the same cycle as a fresh overrun, and a combined write and pop on an empty buffer. Randomised traffic then sweeps every threshold selection.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int RXF_DATA_W = 8;

  typedef struct packed {
    logic                  brk;
    logic                  frm_err;
    logic                  par_err;
    logic [RXF_DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  rx_entry_t        in_entry,
  output rx_entry_t        out_entry,
  output logic [CNT_W-1:0] count
);
  rx_entry_t        slots [DEPTH];
  logic [CNT_W-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) slots[wptr[ADDR_W-1:0]] <= in_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      out_entry <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop) begin
        rptr      <= rptr + 1'b1;
        out_entry <= slots[rptr[ADDR_W-1:0]];
      end
    end
  end

  assign count = wptr - rptr;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R1
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0); // R6
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       sel,
  output logic             data_avail
);
  int thr;

  always_comb begin
    unique case (sel)
      2'd0:    thr = TRIG_0;
      2'd1:    thr = TRIG_1;
      2'd2:    thr = TRIG_2;
      default: thr = TRIG_3;
    endcase
  end

  assign data_avail = int'(count) >= thr;

  AST_TRIG_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |-> !data_avail); // R3
  AST_TRIG_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) == DEPTH |-> data_avail); // R3
endmodule

// File: rtl/rxf_ovr.sv
module rxf_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag); // R5
  AST_OVR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R5
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [RXF_DATA_W-1:0] wr_data,
  input  logic                  wr_par_err,
  input  logic                  wr_frm_err,
  input  logic                  wr_brk,
  input  logic                  rd_en,
  output logic [RXF_DATA_W-1:0] rd_data,
  output logic                  rd_par_err,
  output logic                  rd_frm_err,
  output logic                  rd_brk,
  input  logic [1:0]            trig_sel,
  output logic [CNT_W-1:0]      level,
  output logic                  empty,
  output logic                  data_avail,
  output logic                  overrun,
  input  logic                  ovr_clr
);
  rx_entry_t in_e, out_e;
  logic      full, pop, push, ovr_set;

  assign in_e  = '{brk: wr_brk, frm_err: wr_frm_err, par_err: wr_par_err, data: wr_data};
  assign empty = level == '0;
  assign full  = level == CNT_W'(DEPTH);

  // a pop on a full buffer frees the slot that a same-cycle write uses
  assign pop     = rd_en && !empty;
  assign push    = wr_en && (!full || pop);
  assign ovr_set = wr_en && full && !pop;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .in_entry(in_e), .out_entry(out_e), .count(level)
  );

  rxf_level #(
    .DEPTH(DEPTH), .CNT_W(CNT_W),
    .TRIG_0(TRIG_0), .TRIG_1(TRIG_1), .TRIG_2(TRIG_2), .TRIG_3(TRIG_3)
  ) u_level (
    .clk(clk), .rst_n(rst_n), .count(level), .sel(trig_sel), .data_avail(data_avail)
  );

  rxf_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .set(ovr_set), .clr(ovr_clr), .flag(overrun)
  );

  assign rd_data    = out_e.data;
  assign rd_par_err = out_e.par_err;
  assign rd_frm_err = out_e.frm_err;
  assign rd_brk     = out_e.brk;

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && !full |=> level == CNT_W'($past(level) + 1'b1)); // R1
  AST_OVR_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && full |=> level == CNT_W'(DEPTH) && overrun); // R4
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && empty |=> $stable(rd_data) && $stable(rd_brk) && $stable(rd_frm_err) && $stable(rd_par_err)); // R6
  AST_FULL_RW_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en && full && !overrun |=> level == CNT_W'(DEPTH) && !overrun); // R7
endmodule

// File: tb/tb_rx_fifo_trig.sv
module tb_rx_fifo_trig;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, wr_par_err = 0, wr_frm_err = 0, wr_brk = 0, rd_en = 0, ovr_clr = 0;
  logic [7:0] wr_data = '0;
  logic [1:0] trig_sel = '0;
  logic [7:0] rd_data;
  logic       rd_par_err, rd_frm_err, rd_brk, empty, data_avail, overrun;
  logic [4:0] level;

  int n_chk = 0, n_bad = 0;
  logic [10:0] mq[$];
  logic [10:0] exp_last = '0;
  logic        movr = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rx_fifo_trig dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .wr_brk(wr_brk),
    .rd_en(rd_en), .rd_data(rd_data), .rd_par_err(rd_par_err),
    .rd_frm_err(rd_frm_err), .rd_brk(rd_brk), .trig_sel(trig_sel),
    .level(level), .empty(empty), .data_avail(data_avail),
    .overrun(overrun), .ovr_clr(ovr_clr)
  );

  function automatic int thr_of(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [10:0] mk(int i);
    logic [7:0] d = 8'(i * 37 + 5);
    return {i[2], i[1] ^ i[3], i[0] & i[4], d};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares every output against the scoreboard model
  task automatic monitor();
    chk("R1 level", int'(level), mq.size());
    chk("R1 empty", int'(empty), int'(mq.size() == 0));
    chk("R3 data_avail", int'(data_avail), int'(mq.size() >= thr_of(trig_sel)));
    chk("R5 overrun", int'(overrun), int'(movr));
    chk("R2 read entry", int'({rd_brk, rd_frm_err, rd_par_err, rd_data}), int'(exp_last));
  endtask

  // driver: one cycle of stimulus, scoreboard update, then compare
  task automatic step(input logic w, input logic [10:0] e, input logic r, input logic c);
    logic full_m, rd_ok;
    wr_en = w; {wr_brk, wr_frm_err, wr_par_err, wr_data} = e; rd_en = r; ovr_clr = c;
    @(posedge clk);
    full_m = mq.size() == 16;
    rd_ok  = r && mq.size() > 0;
    if (rd_ok) exp_last = mq.pop_front();
    if (w && (!full_m || rd_ok)) mq.push_back(e);
    if (c) movr = 1'b0;
    if (w && full_m && !rd_ok) movr = 1'b1;
    @(negedge clk);
    wr_en = 0; rd_en = 0; ovr_clr = 0;
    monitor();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [10:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk("R8 level", int'(level), 0);
    chk("R8 empty", int'(empty), 1);
    chk("R8 data_avail", int'(data_avail), 0);
    chk("R8 overrun", int'(overrun), 0);
    chk("R8 read outputs", int'({rd_brk, rd_frm_err, rd_par_err, rd_data}), 0);

    // R1 R2 R3: small burst with assorted flags, threshold 1
    trig_sel = 2'd0;
    for (int i = 0; i < 3; i++) step(1, mk(i + 1), 0, 0);
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0);

    // R3: fill to 16 with threshold 14, sweep selections at the end
    trig_sel = 2'd3;
    for (int i = 0; i < 16; i++) step(1, mk(i + 20), 0, 0);
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      #1 chk("R3 full sweep", int'(data_avail), 1);
    end

    // R4: write while full is discarded
    step(1, 11'h7AA, 0, 0);
    chk("R4 level held at 16", int'(level), 16);
    chk("R4 overrun set", int'(overrun), 1);
    step(0, '0, 0, 1);
    chk("R5 cleared", int'(overrun), 0);
    // R5: clear colliding with a fresh overrun keeps it set
    step(1, 11'h155, 0, 1);
    chk("R5 set wins over clear", int'(overrun), 1);
    step(0, '0, 0, 0);
    chk("R5 sticky", int'(overrun), 1);
    step(0, '0, 0, 1);

    // R7: write and pop together while full
    step(1, mk(99), 1, 0);
    chk("R7 full rw level", int'(level), 16);
    chk("R7 full rw no overrun", int'(overrun), 0);

    // drain: dropped characters never appear, tail holds the R7 write
    trig_sel = 2'd2;
    for (int i = 0; i < 16; i++) step(0, '0, 1, 0);
    chk("R7 tail entry", int'({rd_brk, rd_frm_err, rd_par_err, rd_data}), int'(mk(99)));

    // R6: pop on empty changes nothing
    held = {rd_brk, rd_frm_err, rd_par_err, rd_data};
    step(0, '0, 1, 0);
    chk("R6 read outputs held", int'({rd_brk, rd_frm_err, rd_par_err, rd_data}), int'(held));
    chk("R6 level stays 0", int'(level), 0);

    // R7: write and pop together while empty
    step(1, mk(7), 1, 0);
    chk("R7 empty rw level", int'(level), 1);
    chk("R7 empty rw outputs held", int'({rd_brk, rd_frm_err, rd_par_err, rd_data}), int'(held));
    step(0, '0, 1, 0);

    // random traffic over all thresholds
    for (int i = 0; i < 600; i++) begin
      trig_sel = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 9) < 6), 11'($urandom), ($urandom_range(0, 9) < 4),
           ($urandom_range(0, 19) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule